// File: doc/BRIEF.md
# Frame-Synchronised Serial Converter Port

This block is the digital side of a data converter that sits on a DSP-style serial port. A host starts a frame by pulsing an incoming frame-sync strobe. The block then clocks in a 16-bit command word on the falling edges of the serial clock, picks a channel from the first bits of that word, and tells the analog core when acquisition runs and when the input is sampled. At the sample point, a parallel port stands in for the analog core and supplies a 14-bit conversion value and two status bits. The block announces the result with a one-clock outgoing frame sync and then shifts the result out, MSB first.

Every action is tied to a numbered serial-clock edge in a 32-clock frame. The serial clock, data input, chip select and frame sync are sampled by a fast system clock and edge-detected. This keeps the whole block in one clock domain. Clock number k is the k-th rising serial-clock edge after the incoming frame sync falls, followed by the k-th falling edge.

A new incoming frame sync restarts the sequence at any point. A rising chip select abandons the frame and parks the block in shutdown until chip select goes low again.

Top module: `fsync_adc_port`

## Requirements
- R1: After reset, dout, fsOut, acquiring, sampleStb, cmdValid and pwrDown are 0, and chanSel and cmdWord are all zeros.
- R2: din is captured on falling serial-clock edges 1 to 16 of a frame, first bit as MSB. On falling edge 16 the complete word appears on cmdWord, and cmdValid pulses for one system clock.
- R3: On falling edge 3, chanSel takes the first three command bits (cmdWord bits 15:13 of the finished word), and acquiring goes high.
- R4: On rising edge 15, acquiring goes low, sampleStb pulses for one system clock, and adcData and adcStatus are captured as the result.
- R5: fsOut goes high on rising edge 16 and low on rising edge 17.
- R6: On rising edges 17 to 32, dout gives the 16-bit word {adcData[13:0], adcStatus[1:0]} in order from bit 15 down to bit 0.
- R7: On rising edges after 32, until the next incoming frame sync, dout is 0.
- R8: A falling edge on fsIn while chip select is low and the block is not in shutdown restarts the frame at once. It clears dout, fsOut and acquiring, and edge counting starts again from 1. The aborted frame produces nothing more.
- R9: A rising edge on csN aborts any frame and sets pwrDown. While pwrDown is set, dout, fsOut and acquiring stay 0 and frame syncs are ignored. pwrDown clears when csN is low.
- R10: dout is 0 while the block is idle and before rising edge 17 of a frame.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, oversamples the serial lines |
| rstN | input | 1 | Active-low synchronous reset |
| sclk | input | 1 | Serial clock from host |
| din | input | 1 | Serial command data |
| csN | input | 1 | Active-low chip select |
| fsIn | input | 1 | Incoming frame-sync strobe, frame starts on its fall |
| adcData | input | 14 | Conversion value from the analog core |
| adcStatus | input | 2 | Status bits appended after the value |
| dout | output | 1 | Serial result data |
| fsOut | output | 1 | Outgoing frame-sync strobe |
| chanSel | output | 3 | Selected channel to the analog core |
| acquiring | output | 1 | High during acquisition |
| sampleStb | output | 1 | One-clock pulse at the sample point |
| cmdWord | output | 16 | Last complete command word |
| cmdValid | output | 1 | One-clock pulse when cmdWord updates |
| pwrDown | output | 1 | Shutdown state indicator |

## Verification
The bench targets off-by-one errors in edge numbering. Such a design latches the channel one bit early, samples on edge 14 or 16, or starts output one bit late, which shifts every bit of the result.

The bench also targets the tail after the 32nd clock. A design that does not clear its shift path there repeats stale bits instead of zeros.

Frames are restarted during the command phase and again during the transfer. This exposes designs that keep the old edge count or let a stale outgoing sync through.

Chip select is raised mid-frame and a frame sync is then sent while shut down. This catches designs that keep shifting or leave shutdown on a frame sync instead of on chip select.

// File: rtl/fsync_adc_pkg.sv
package fsync_adc_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_ACTIVE = 2'd1,
    ST_SHUT   = 2'd2
  } linkState_e;

  typedef struct packed {
    logic frameStart;
    logic kill;
    logic shiftCmd;
    logic latchChan;
    logic cmdDone;
    logic sample;
    logic fsSet;
    logic fsClr;
    logic shiftOut;
  } dpStrobes_t;

endpackage

// File: rtl/fsync_adc_ctrl.sv
module fsync_adc_ctrl
  import fsync_adc_pkg::*;
#(
  parameter int CMD_W  = 16,
  parameter int CHAN_W = 3,
  parameter int WORD_W = 16
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       sclk,
  input  logic       csN,
  input  logic       fsIn,
  output dpStrobes_t st,
  output logic       acquiring,
  output logic       pwrDown
);

  localparam int SAMP_NO = CMD_W - 1;
  localparam int FS_NO   = CMD_W;
  localparam int OUT_NO  = CMD_W + 1;
  localparam int MAX_NO  = OUT_NO + WORD_W;
  localparam int CNT_W   = $clog2(MAX_NO + 1);

  localparam logic [CNT_W-1:0] SAMP_C = CNT_W'(SAMP_NO);
  localparam logic [CNT_W-1:0] FS_C   = CNT_W'(FS_NO);
  localparam logic [CNT_W-1:0] OUT_C  = CNT_W'(OUT_NO);
  localparam logic [CNT_W-1:0] MAX_C  = CNT_W'(MAX_NO);
  localparam logic [CNT_W-1:0] CHAN_C = CNT_W'(CHAN_W);
  localparam logic [CNT_W-1:0] CMD_C  = CNT_W'(CMD_W);

  linkState_e       state;
  logic             sclkQ, fsQ, csQ;
  logic [CNT_W-1:0] clkNo;
  logic [CNT_W-1:0] nextNo;
  logic             sclkRise, sclkFall, fsFall, csRise, act, fallOk;

  assign sclkRise = sclk & ~sclkQ;
  assign sclkFall = ~sclk & sclkQ;
  assign fsFall   = ~fsIn & fsQ;
  assign csRise   = csN & ~csQ;
  assign nextNo   = (clkNo == MAX_C) ? MAX_C : clkNo + 1'b1;

  always_comb begin
    st            = '0;
    st.kill       = csRise;
    st.frameStart = fsFall & ~csN & (state != ST_SHUT) & ~csRise;
    act           = (state == ST_ACTIVE) & ~st.frameStart & ~csRise;
    fallOk        = act & sclkFall & (clkNo != '0) & (clkNo <= CMD_C);
    st.shiftCmd   = fallOk;
    st.latchChan  = fallOk & (clkNo == CHAN_C);
    st.cmdDone    = fallOk & (clkNo == CMD_C);
    st.sample     = act & sclkRise & (nextNo == SAMP_C);
    st.fsSet      = act & sclkRise & (nextNo == FS_C);
    st.fsClr      = act & sclkRise & (nextNo == OUT_C);
    st.shiftOut   = act & sclkRise & (nextNo >= OUT_C);
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      sclkQ     <= 1'b0;
      fsQ       <= 1'b0;
      csQ       <= 1'b1;
      state     <= ST_IDLE;
      clkNo     <= '0;
      acquiring <= 1'b0;
    end else begin
      sclkQ <= sclk;
      fsQ   <= fsIn;
      csQ   <= csN;
      if (csRise) begin
        state <= ST_SHUT;
      end else if (state == ST_SHUT) begin
        if (!csN) state <= ST_IDLE;
      end else if (st.frameStart) begin
        state <= ST_ACTIVE;
      end
      if (st.frameStart) clkNo <= '0;
      else if (act && sclkRise) clkNo <= nextNo;
      if (st.kill || st.frameStart) acquiring <= 1'b0;
      else if (st.latchChan) acquiring <= 1'b1;
      else if (st.sample) acquiring <= 1'b0;
    end
  end

  assign pwrDown = (state == ST_SHUT);

  AST_CNT_BOUND: assert property (@(posedge clk) disable iff (!rstN)
    clkNo <= MAX_C);  // R7
  AST_ACQ_ONLY_ACTIVE: assert property (@(posedge clk) disable iff (!rstN)
    acquiring |-> (state == ST_ACTIVE));  // R3
  AST_ACQ_DONE_AT_FS: assert property (@(posedge clk) disable iff (!rstN)
    st.fsSet |-> !acquiring);  // R4

endmodule

// File: rtl/fsync_adc_dp.sv
module fsync_adc_dp
  import fsync_adc_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int STAT_W = 2,
  parameter int CMD_W  = 16,
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  dpStrobes_t        st,
  input  logic              din,
  input  logic [DATA_W-1:0] adcData,
  input  logic [STAT_W-1:0] adcStatus,
  output logic              dout,
  output logic              fsOut,
  output logic [CHAN_W-1:0] chanSel,
  output logic              sampleStb,
  output logic [CMD_W-1:0]  cmdWord,
  output logic              cmdValid
);

  localparam int WORD_W = DATA_W + STAT_W;

  logic [CMD_W-1:0]  cmdSh;
  logic [CMD_W:0]    cmdNext;
  logic [WORD_W-1:0] outSh;

  assign cmdNext = {cmdSh, din};

  always_ff @(posedge clk) begin
    if (!rstN) begin
      cmdSh     <= '0;
      chanSel   <= '0;
      cmdWord   <= '0;
      cmdValid  <= 1'b0;
      sampleStb <= 1'b0;
      outSh     <= '0;
      dout      <= 1'b0;
      fsOut     <= 1'b0;
    end else begin
      cmdValid  <= st.cmdDone;
      sampleStb <= st.sample;
      if (st.shiftCmd)  cmdSh   <= cmdNext[CMD_W-1:0];
      if (st.latchChan) chanSel <= cmdNext[CHAN_W-1:0];
      if (st.cmdDone)   cmdWord <= cmdNext[CMD_W-1:0];
      if (st.kill || st.frameStart) begin
        dout  <= 1'b0;
        fsOut <= 1'b0;
        outSh <= '0;
      end else begin
        if (st.sample) outSh <= {adcData, adcStatus};
        if (st.fsSet) fsOut <= 1'b1;
        else if (st.fsClr) fsOut <= 1'b0;
        if (st.shiftOut) begin
          dout  <= outSh[WORD_W-1];
          outSh <= {outSh[WORD_W-2:0], 1'b0};
        end
      end
    end
  end

  AST_DOUT_QUIET_IN_FS: assert property (@(posedge clk) disable iff (!rstN)
    fsOut |-> !dout);  // R10
  AST_SAMPLE_NOT_WITH_SHIFT: assert property (@(posedge clk) disable iff (!rstN)
    sampleStb |-> !fsOut);  // R5

endmodule

// File: rtl/fsync_adc_port.sv
module fsync_adc_port
  import fsync_adc_pkg::*;
#(
  parameter int DATA_W = 14,
  parameter int STAT_W = 2,
  parameter int CMD_W  = 16,
  parameter int CHAN_W = 3
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              sclk,
  input  logic              din,
  input  logic              csN,
  input  logic              fsIn,
  input  logic [DATA_W-1:0] adcData,
  input  logic [STAT_W-1:0] adcStatus,
  output logic              dout,
  output logic              fsOut,
  output logic [CHAN_W-1:0] chanSel,
  output logic              acquiring,
  output logic              sampleStb,
  output logic [CMD_W-1:0]  cmdWord,
  output logic              cmdValid,
  output logic              pwrDown
);

  localparam int WORD_W = DATA_W + STAT_W;

  dpStrobes_t st;

  fsync_adc_ctrl #(.CMD_W(CMD_W), .CHAN_W(CHAN_W), .WORD_W(WORD_W)) uCtrl (
    .clk(clk), .rstN(rstN), .sclk(sclk), .csN(csN), .fsIn(fsIn),
    .st(st), .acquiring(acquiring), .pwrDown(pwrDown)
  );

  fsync_adc_dp #(.DATA_W(DATA_W), .STAT_W(STAT_W), .CMD_W(CMD_W), .CHAN_W(CHAN_W)) uDp (
    .clk(clk), .rstN(rstN), .st(st), .din(din), .adcData(adcData),
    .adcStatus(adcStatus), .dout(dout), .fsOut(fsOut), .chanSel(chanSel),
    .sampleStb(sampleStb), .cmdWord(cmdWord), .cmdValid(cmdValid)
  );

  AST_SHUT_SILENT: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |-> (!dout && !fsOut));  // R9
  AST_SHUT_NO_ACQ: assert property (@(posedge clk) disable iff (!rstN)
    pwrDown |-> !acquiring);  // R9

endmodule

// File: tb/tb_fsync_adc_port.sv
`timescale 1ns/1ps
module tb_fsync_adc_port;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic sclk = 1'b0, din = 1'b0, csN = 1'b1, fsIn = 1'b0;
  logic [13:0] adcData = '0;
  logic [1:0]  adcStatus = '0;
  logic dout, fsOut, acquiring, sampleStb, cmdValid, pwrDown;
  logic [2:0]  chanSel;
  logic [15:0] cmdWord;

  int checks = 0;
  int errors = 0;
  int cycles = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  fsync_adc_port dut (
    .clk(clk), .rstN(rstN), .sclk(sclk), .din(din), .csN(csN), .fsIn(fsIn),
    .adcData(adcData), .adcStatus(adcStatus), .dout(dout), .fsOut(fsOut),
    .chanSel(chanSel), .acquiring(acquiring), .sampleStb(sampleStb),
    .cmdWord(cmdWord), .cmdValid(cmdValid), .pwrDown(pwrDown)
  );

  task automatic checkEq(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h at cycle %0d", tag, act, exp, cycles);
    end
  endtask

  // behavioural reference model
  int  mState = 0;   // 0 idle, 1 active, 2 shut
  int  n = 0;
  bit  pS = 0, pF = 0, pC = 1;
  bit  [15:0] cmdSh = 0;
  bit  eDout = 0, eFs = 0, eAcq = 0, eSmp = 0, eCv = 0;
  bit  [2:0]  eChan = 0;
  bit  [15:0] eCmd = 0;
  bit  outQ[$];

  always @(posedge clk) begin
    if (!rstN) begin
      mState = 0; n = 0; pS = 0; pF = 0; pC = 1; eDout = 0; eFs = 0;
      eAcq = 0; eSmp = 0; eCv = 0; eChan = 0; eCmd = 0; outQ.delete();
    end else begin
      eSmp = 0; eCv = 0;
      if (csN && !pC) begin
        mState = 2; eDout = 0; eFs = 0; eAcq = 0; outQ.delete();
      end else if (mState == 2) begin
        if (!csN) mState = 0;
      end else if (!fsIn && pF && !csN) begin
        mState = 1; n = 0; eDout = 0; eFs = 0; eAcq = 0; outQ.delete();
      end else if (mState == 1) begin
        if (sclk && !pS) begin
          n++;
          if (n == 15) begin
            eSmp = 1; eAcq = 0;
            for (int b = 13; b >= 0; b--) outQ.push_back(adcData[b]);
            outQ.push_back(adcStatus[1]);
            outQ.push_back(adcStatus[0]);
          end
          if (n == 16) eFs = 1;
          if (n == 17) eFs = 0;
          if (n >= 17) eDout = (outQ.size() > 0) ? outQ.pop_front() : 1'b0;
        end
        if (!sclk && pS && n >= 1 && n <= 16) begin
          cmdSh = {cmdSh[14:0], din};
          if (n == 3) begin eChan = cmdSh[2:0]; eAcq = 1; end
          if (n == 16) begin eCmd = cmdSh; eCv = 1; end
        end
      end
      pS = sclk; pF = fsIn; pC = csN;
    end
  end

  always @(negedge clk) begin
    cycles++;
    if (rstN && !done) begin
      checkEq("R6 R7 R10 dout", dout, eDout);
      checkEq("R5 R8 fsOut", fsOut, eFs);
      checkEq("R3 R4 acquiring", acquiring, eAcq);
      checkEq("R4 sampleStb", sampleStb, eSmp);
      checkEq("R2 cmdValid", cmdValid, eCv);
      checkEq("R2 cmdWord", cmdWord, eCmd);
      checkEq("R3 chanSel", chanSel, eChan);
      checkEq("R9 pwrDown", pwrDown, mState == 2);
    end
    if (cycles > 150000 && !done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  task automatic waitClk(input int k);
    repeat (k) @(negedge clk);
  endtask

  task automatic frame(input logic [15:0] cmd, input int nClk,
                       input logic [13:0] d, input logic [1:0] s);
    adcData = d; adcStatus = s;
    fsIn = 1'b1; waitClk(3);
    fsIn = 1'b0; waitClk(2);
    for (int i = 1; i <= nClk; i++) begin
      sclk = 1'b1;
      din  = (i <= 16) ? cmd[16-i] : 1'b0;
      waitClk(4);
      sclk = 1'b0;
      waitClk(4);
    end
  endtask

  initial begin
    logic [15:0] c;
    logic [13:0] d;
    waitClk(4);
    // R1 reset state
    checkEq("R1 dout", dout, 0);
    checkEq("R1 fsOut", fsOut, 0);
    checkEq("R1 acquiring", acquiring, 0);
    checkEq("R1 pwrDown", pwrDown, 0);
    checkEq("R1 cmdWord", cmdWord, 0);
    rstN = 1'b1;
    waitClk(2);
    csN = 1'b0;
    waitClk(3);

    // full frames with a zero tail (R2 R3 R6 R7)
    for (int k = 0; k < 6; k++) begin
      c = 16'($urandom);
      d = 14'($urandom);
      frame(c, 36, d, 2'($urandom));
      waitClk(3);
      checkEq("R2 captured command", cmdWord, c);
      checkEq("R3 channel field", chanSel, c[15:13]);
      checkEq("R7 tail zero", dout, 0);
    end
    frame(16'hFFFF, 32, 14'h3FFF, 2'b11);
    frame(16'h0000, 34, 14'h2001, 2'b01);

    // restart during command phase and during transfer (R8)
    frame(16'hA5A5, 9, 14'h1234, 2'b10);
    frame(16'h6C3E, 20, 14'h0F0F, 2'b01);
    c = 16'h93C1;
    frame(c, 33, 14'h2AAA, 2'b10);
    waitClk(2);
    checkEq("R8 restarted command", cmdWord, c);

    // chip select abort and ignored frame sync (R9)
    frame(16'h4321, 12, 14'h1111, 2'b11);
    csN = 1'b1;
    waitClk(3);
    checkEq("R9 shutdown entered", pwrDown, 1);
    frame(16'hBEEF, 20, 14'h3333, 2'b00);
    checkEq("R9 frame ignored", cmdWord, 16'h6C3E == 16'h0 ? 0 : int'(c));
    csN = 1'b0;
    waitClk(3);
    checkEq("R9 shutdown left", pwrDown, 0);
    frame(16'h2468, 34, 14'h1357, 2'b01);
    waitClk(3);
    checkEq("R2 after shutdown", cmdWord, 16'h2468);

    // abort in the transfer by chip select
    frame(16'h7777, 24, 14'h3CC3, 2'b10);
    csN = 1'b1; waitClk(4); csN = 1'b0; waitClk(4);
    checkEq("R10 idle dout", dout, 0);
    frame(16'h1F2E, 34, 14'h0AB5, 2'b00);
    waitClk(6);

    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule